// File: doc/BRIEF.md
# Ordered Sub-Pattern Chain Recogniser

This block is the second stage of a two-stage signature matcher. The first stage finds fixed-length pieces of SEG_LEN symbols and reports each hit as a piece index. It also reports tails shorter than SEG_LEN as remnant hits, and reports whole signatures shorter than SEG_LEN as short hits. The first stage consumes one input symbol per clock cycle, and each event marks the cycle in which the matched piece ends. This block recognises a long signature. A long signature is an ordered list of 1 to MAX_SEG piece indices, each ending exactly SEG_LEN cycles after the one before it. A remnant index then has to end exactly its own length after the last piece.

Each long signature has its own progress tracker. The tracker holds how many pieces have matched in order and how many cycles have passed since the last of them. A small table holds the ordered piece indices, the remnant index, the remnant length and the piece count for each signature. The table is filled through a write port. When a chain completes, the block raises a one-cycle pulse carrying the signature number. Short hits are passed through on a separate output with the same one-cycle latency. A flush input clears all progress at a packet boundary.

Top module: `sp_chain_matcher`

## Requirements
- R1: After reset, long_vld and short_vld are low. Every tracker is idle, so a chain started before reset cannot complete.
- R2: A write with cfg_we high stores cfg_data into the entry of signature cfg_pat. The field is picked by cfg_field: 0 stores piece cfg_slot, 1 stores the remnant index, 2 stores the remnant length (low bits), 3 stores the piece count (low bits). The write takes effect from the next cycle.
- R3: A tracker advances by one piece only when the next piece index in its list arrives exactly SEG_LEN cycles after the previous piece hit. The first piece may arrive at any time while the tracker is idle.
- R4: When all pieces have matched and the remnant index arrives exactly remnant-length cycles after the last piece, long_vld is high for one cycle in the next cycle, and long_idx holds the signature number.
- R5: At the cycle a piece is due, a missing or wrong index ends the chain. If the arriving index is the signature's first piece, the tracker restarts with one piece matched.
- R6: A remnant hit at any other distance than the stored remnant length, or with a different index, reports nothing, and the chain ends at its due cycle.
- R7: When several signatures complete in the same cycle, long_idx holds the lowest signature number.
- R8: A short hit (s_vld, s_idx) appears on short_vld and short_idx one cycle later. This happens whatever the long-signature path is doing, including in the same cycle as a long report.
- R9: flush clears every tracker. Piece and remnant events in the flush cycle are discarded, and no long report follows that cycle.
- R10: A signature whose piece count is 0 never advances and is never reported.
- R11: While a chain is between due cycles, piece hits that arrive at other distances are ignored and do not disturb it. This includes hits of its own first piece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one input symbol per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clears all chain progress (packet boundary) |
| q_vld | input | 1 | A fixed-length piece ends this cycle |
| q_idx | input | IDX_W | Index of that piece |
| r_vld | input | 1 | A remnant ends this cycle |
| r_idx | input | IDX_W | Index of that remnant |
| s_vld | input | 1 | A short signature ends this cycle |
| s_idx | input | IDX_W | Index of that short signature |
| cfg_we | input | 1 | Table write strobe |
| cfg_pat | input | PAT_W | Signature entry to write |
| cfg_field | input | 2 | Field select: 0 piece, 1 remnant index, 2 remnant length, 3 piece count |
| cfg_slot | input | SLOT_W | Piece position for field 0 |
| cfg_data | input | IDX_W | Value to write |
| long_vld | output | 1 | One-cycle long-signature report |
| long_idx | output | PAT_W | Reported signature number |
| short_vld | output | 1 | Registered short-hit report |
| short_idx | output | IDX_W | Registered short-hit index |

## Verification
Two cases can collide in one cycle. In the first, two signatures finish together: two entries share one piece and remnant, and one remnant hit completes both, so long_idx must carry the lower number. In the second, a long report coincides with a short hit: a short hit is driven in the same cycle as a completing remnant, and both outputs must be high together in the next cycle with their own indices. Timing edges are probed as well. Pieces arrive one cycle early, one cycle late and at an off-grid distance, and remnants arrive at the wrong distance. Before each such probe, the bench works out on every cycle whether a report is expected.

// File: rtl/sp_chain_pkg.sv
// Package: shared field encodings for the chain recogniser's table write port.
// Assumes: the encodings below are the ones stated in the block's requirements.
package sp_chain_pkg;
    typedef enum logic [1:0] {
        FLD_PIECE   = 2'd0,
        FLD_REM_IDX = 2'd1,
        FLD_REM_LEN = 2'd2,
        FLD_COUNT   = 2'd3
    } cfg_field_e;
endpackage

// File: rtl/sp_seq_table.sv
// Module: sp_seq_table
// Holds, per long signature, its ordered piece indices, remnant index,
// remnant length and piece count. Flop-based with a single write port; all
// entries are read in parallel by the trackers.
// Assumes: only the piece count needs a reset value (count 0 disables an entry).
module sp_seq_table
    import sp_chain_pkg::*;
#(
    parameter int NUM_PAT = 16,
    parameter int MAX_SEG = 8,
    parameter int SEG_LEN = 4,
    parameter int IDX_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [$clog2(NUM_PAT)-1:0]    cfg_pat,
    input  logic [1:0]                    cfg_field,
    input  logic [$clog2(MAX_SEG)-1:0]    cfg_slot,
    input  logic [IDX_W-1:0]              cfg_data,
    output logic [MAX_SEG*IDX_W-1:0]      seq_o  [NUM_PAT],
    output logic [IDX_W-1:0]              ridx_o [NUM_PAT],
    output logic [$clog2(SEG_LEN+2)-1:0]  rlen_o [NUM_PAT],
    output logic [$clog2(MAX_SEG+1)-1:0]  nseg_o [NUM_PAT]
);
    localparam int AGE_W = $clog2(SEG_LEN + 2);
    localparam int CNT_W = $clog2(MAX_SEG + 1);

    cfg_field_e fld;
    assign fld = cfg_field_e'(cfg_field);

    // Data fields: written on demand, no reset needed.
    always_ff @(posedge clk) begin
        if (cfg_we) begin
            case (fld)
                FLD_PIECE:   seq_o[cfg_pat][cfg_slot*IDX_W +: IDX_W] <= cfg_data;
                FLD_REM_IDX: ridx_o[cfg_pat] <= cfg_data;
                FLD_REM_LEN: rlen_o[cfg_pat] <= cfg_data[AGE_W-1:0];
                default: ;
            endcase
        end
    end

    // Piece counts: reset to zero so every entry starts disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAT; p++) nseg_o[p] <= '0;
        end else if (cfg_we && fld == FLD_COUNT) begin
            nseg_o[cfg_pat] <= cfg_data[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/sp_seg_tracker.sv
// Module: sp_seg_tracker
// Progress tracker for one long signature. Counts pieces matched in order and
// the cycles since the last piece hit. Raises done (combinational) in the cycle
// the remnant lands exactly remnant-length cycles after the last piece.
// Assumes: one symbol per cycle; remnant length in 1..SEG_LEN-1; at most one
// piece event and one remnant event per cycle.
module sp_seg_tracker #(
    parameter int MAX_SEG = 8,
    parameter int SEG_LEN = 4,
    parameter int IDX_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          q_vld,
    input  logic [IDX_W-1:0]              q_idx,
    input  logic                          r_vld,
    input  logic [IDX_W-1:0]              r_idx,
    input  logic [MAX_SEG*IDX_W-1:0]      seq,
    input  logic [IDX_W-1:0]              ridx,
    input  logic [$clog2(SEG_LEN+2)-1:0]  rlen,
    input  logic [$clog2(MAX_SEG+1)-1:0]  nseg,
    output logic                          done
);
    localparam int SLOT_W  = $clog2(MAX_SEG);
    localparam int CNT_W   = $clog2(MAX_SEG + 1);
    localparam int AGE_W   = $clog2(SEG_LEN + 2);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SEG_LEN + 1);
    localparam logic [AGE_W-1:0] AGE_DUE = AGE_W'(SEG_LEN);

    logic [IDX_W-1:0] seq_arr [MAX_SEG];
    logic [CNT_W-1:0] prog, prog_d;
    logic [AGE_W-1:0] age, age_d;
    logic             enabled, q_first, q_next, piece_due, rem_due;

    for (genvar s = 0; s < MAX_SEG; s++) begin : g_unpack
        assign seq_arr[s] = seq[s*IDX_W +: IDX_W];
    end

    assign enabled   = (nseg != '0);
    assign q_first   = q_vld && (q_idx == seq_arr[0]);
    assign q_next    = q_vld && (q_idx == seq_arr[prog[SLOT_W-1:0]]);
    assign piece_due = (prog != '0) && (prog < nseg) && (age == AGE_DUE);
    assign rem_due   = (prog != '0) && (prog == nseg) && (age == rlen);
    assign done      = enabled && rem_due && r_vld && (r_idx == ridx) && !flush;

    // Next progress and age: advance on a due hit, restart on the first piece, else drop.
    always_comb begin
        prog_d = prog;
        age_d  = (age == AGE_MAX) ? age : age + 1'b1;
        if (!enabled || prog > nseg) begin
            prog_d = '0;
        end else if (piece_due) begin
            if (q_next) begin
                prog_d = prog + 1'b1;
                age_d  = AGE_W'(1);
            end else if (q_first) begin
                prog_d = CNT_W'(1);
                age_d  = AGE_W'(1);
            end else begin
                prog_d = '0;
            end
        end else if (rem_due) begin
            if (q_first) begin
                prog_d = CNT_W'(1);
                age_d  = AGE_W'(1);
            end else begin
                prog_d = '0;
            end
        end else if (prog == '0) begin
            if (q_first) begin
                prog_d = CNT_W'(1);
                age_d  = AGE_W'(1);
            end
        end else if (age == AGE_MAX) begin
            prog_d = '0;
        end
    end

    // State register: cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            prog <= '0;
            age  <= '0;
        end else begin
            prog <= prog_d;
            age  <= age_d;
        end
    end
endmodule

// File: rtl/sp_pick_lowest.sv
// Module: sp_pick_lowest
// Registers a one-cycle report of the lowest-numbered completed signature.
// Assumes: done bits are single-cycle strobes from the trackers.
module sp_pick_lowest #(
    parameter int NUM_PAT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PAT-1:0]         done,
    output logic                       long_vld,
    output logic [$clog2(NUM_PAT)-1:0] long_idx
);
    localparam int PAT_W = $clog2(NUM_PAT);

    logic [PAT_W-1:0] win;

    // Priority search: scanning downward leaves the lowest set bit.
    always_comb begin
        win = '0;
        for (int i = NUM_PAT - 1; i >= 0; i--) begin
            if (done[i]) win = PAT_W'(i);
        end
    end

    // Output register: one pulse per completion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_vld <= 1'b0;
            long_idx <= '0;
        end else begin
            long_vld <= |done;
            long_idx <= win;
        end
    end
endmodule

// File: rtl/sp_chain_matcher.sv
// Module: sp_chain_matcher (top)
// Recognises long signatures as ordered chains of fixed-length piece hits
// followed by a remnant hit. Passes short-signature hits through.
// Assumes: the first stage delivers one symbol per cycle and reports each hit
// in the cycle its last symbol is consumed.
module sp_chain_matcher #(
    parameter int NUM_PAT = 16,
    parameter int MAX_SEG = 8,
    parameter int SEG_LEN = 4,
    parameter int IDX_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       q_vld,
    input  logic [IDX_W-1:0]           q_idx,
    input  logic                       r_vld,
    input  logic [IDX_W-1:0]           r_idx,
    input  logic                       s_vld,
    input  logic [IDX_W-1:0]           s_idx,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_PAT)-1:0] cfg_pat,
    input  logic [1:0]                 cfg_field,
    input  logic [$clog2(MAX_SEG)-1:0] cfg_slot,
    input  logic [IDX_W-1:0]           cfg_data,
    output logic                       long_vld,
    output logic [$clog2(NUM_PAT)-1:0] long_idx,
    output logic                       short_vld,
    output logic [IDX_W-1:0]           short_idx
);
    localparam int PAT_W = $clog2(NUM_PAT);
    localparam int CNT_W = $clog2(MAX_SEG + 1);
    localparam int AGE_W = $clog2(SEG_LEN + 2);

    logic [MAX_SEG*IDX_W-1:0] seq_t  [NUM_PAT];
    logic [IDX_W-1:0]         ridx_t [NUM_PAT];
    logic [AGE_W-1:0]         rlen_t [NUM_PAT];
    logic [CNT_W-1:0]         nseg_t [NUM_PAT];
    logic [NUM_PAT-1:0]       done_vec;

    sp_seq_table #(
        .NUM_PAT(NUM_PAT), .MAX_SEG(MAX_SEG), .SEG_LEN(SEG_LEN), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pat(cfg_pat),
        .cfg_field(cfg_field), .cfg_slot(cfg_slot), .cfg_data(cfg_data),
        .seq_o(seq_t), .ridx_o(ridx_t), .rlen_o(rlen_t), .nseg_o(nseg_t)
    );

    for (genvar p = 0; p < NUM_PAT; p++) begin : g_trk
        sp_seg_tracker #(
            .MAX_SEG(MAX_SEG), .SEG_LEN(SEG_LEN), .IDX_W(IDX_W)
        ) u_trk (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .q_vld(q_vld), .q_idx(q_idx), .r_vld(r_vld), .r_idx(r_idx),
            .seq(seq_t[p]), .ridx(ridx_t[p]), .rlen(rlen_t[p]), .nseg(nseg_t[p]),
            .done(done_vec[p])
        );
    end

    sp_pick_lowest #(.NUM_PAT(NUM_PAT)) u_pick (
        .clk(clk), .rst_n(rst_n), .done(done_vec),
        .long_vld(long_vld), .long_idx(long_idx)
    );

    // Short-hit pass-through register, same latency as long reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_vld <= 1'b0;
            short_idx <= '0;
        end else begin
            short_vld <= s_vld;
            short_idx <= s_idx;
        end
    end
endmodule

// File: rtl/sp_chain_checker.sv
// Module: sp_chain_checker
// Temporal checks on the chain recogniser, attached to the top by bind.
// Assumes: done is the per-signature completion vector inside the top.
module sp_chain_checker #(
    parameter int NUM_PAT = 16,
    parameter int IDX_W   = 8,
    parameter int PAT_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               r_vld,
    input logic               s_vld,
    input logic [IDX_W-1:0]   s_idx,
    input logic [NUM_PAT-1:0] done,
    input logic               long_vld,
    input logic [PAT_W-1:0]   long_idx,
    input logic               short_vld,
    input logic [IDX_W-1:0]   short_idx
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !long_vld && !short_vld); // R1
    AST_REPORT_NEEDS_REMNANT: assert property (@(posedge clk) disable iff (!rst_n)
        long_vld |-> $past(r_vld) && !$past(flush)); // R4
    AST_FLUSH_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !long_vld); // R9
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        done[0] |=> long_vld && long_idx == '0); // R7
    AST_SHORT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        s_vld |=> short_vld && short_idx == $past(s_idx)); // R8
endmodule

bind sp_chain_matcher sp_chain_checker #(
    .NUM_PAT(NUM_PAT), .IDX_W(IDX_W), .PAT_W(PAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .r_vld(r_vld),
    .s_vld(s_vld), .s_idx(s_idx), .done(done_vec),
    .long_vld(long_vld), .long_idx(long_idx),
    .short_vld(short_vld), .short_idx(short_idx)
);

// File: tb/tb_sp_chain_matcher.sv
// Directed bench: inputs change just after a falling edge; outputs are read
// at the next falling edge, which follows the rising edge that consumed them.
module tb_sp_chain_matcher;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, flush = 1'b0;
    logic       q_vld = 1'b0, r_vld = 1'b0, s_vld = 1'b0;
    logic [7:0] q_idx = '0, r_idx = '0, s_idx = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_pat = '0;
    logic [1:0] cfg_field = '0;
    logic [2:0] cfg_slot = '0;
    logic [7:0] cfg_data = '0;
    logic       long_vld, short_vld;
    logic [3:0] long_idx;
    logic [7:0] short_idx;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_chain_matcher dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .q_vld(q_vld), .q_idx(q_idx), .r_vld(r_vld), .r_idx(r_idx),
        .s_vld(s_vld), .s_idx(s_idx),
        .cfg_we(cfg_we), .cfg_pat(cfg_pat), .cfg_field(cfg_field),
        .cfg_slot(cfg_slot), .cfg_data(cfg_data),
        .long_vld(long_vld), .long_idx(long_idx),
        .short_vld(short_vld), .short_idx(short_idx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One symbol cycle: drive events, then check both outputs one cycle later.
    task automatic tick(input bit qv, input int qi, input bit rv, input int ri,
                        input bit sv, input int si, input bit fl,
                        input bit el, input int ei, input string tag);
        q_vld = qv; q_idx = 8'(qi); r_vld = rv; r_idx = 8'(ri);
        s_vld = sv; s_idx = 8'(si); flush = fl;
        @(negedge clk);
        chk(long_vld == el, {tag, " long_vld"}, long_vld, el);
        if (el) chk(long_idx == 4'(ei), {tag, " long_idx"}, long_idx, ei);
        chk(short_vld == sv, "R8 short_vld", short_vld, sv);
        if (sv) chk(short_idx == 8'(si), "R8 short_idx", short_idx, si);
        q_vld = 0; r_vld = 0; s_vld = 0; flush = 0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic cfg(input int pat, input int fld, input int slot, input int data);
        cfg_we = 1; cfg_pat = 4'(pat); cfg_field = 2'(fld);
        cfg_slot = 3'(slot); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // R2: field 0 piece, 1 remnant index, 2 remnant length, 3 piece count.
    task automatic load_table();
        cfg(3, 0, 0, 10); cfg(3, 0, 1, 11); cfg(3, 1, 0, 50); cfg(3, 2, 0, 2); cfg(3, 3, 0, 2);
        cfg(5, 0, 0, 20); cfg(5, 1, 0, 60); cfg(5, 2, 0, 3); cfg(5, 3, 0, 1);
        cfg(7, 0, 0, 20); cfg(7, 1, 0, 60); cfg(7, 2, 0, 3); cfg(7, 3, 0, 1);
        cfg(9, 0, 0, 30); cfg(9, 0, 1, 31); cfg(9, 0, 2, 32); cfg(9, 1, 0, 70);
        cfg(9, 2, 0, 1); cfg(9, 3, 0, 3);
    endtask

    task automatic t_reset();
        chk(long_vld == 0, "R1 long_vld after reset", long_vld, 0);
        chk(short_vld == 0, "R1 short_vld after reset", short_vld, 0);
    endtask

    task automatic t_basic();
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R3");
        idle(3, "R3");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R3");
        idle(1, "R4");
        tick(0, 0, 1, 50, 0, 0, 0, 1, 3, "R4 report");
        idle(1, "R4 pulse ends");
        idle(6, "R4");
    endtask

    task automatic t_three_pieces();
        tick(1, 30, 0, 0, 0, 0, 0, 0, 0, "R3");
        idle(3, "R3");
        tick(1, 31, 0, 0, 0, 0, 0, 0, 0, "R3");
        idle(3, "R3");
        tick(1, 32, 0, 0, 0, 0, 0, 0, 0, "R3");
        tick(0, 0, 1, 70, 0, 0, 0, 1, 9, "R3 three-piece report");
        idle(6, "R3");
    endtask

    task automatic t_mistimed();
        // late second piece
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R5");
        idle(4, "R5");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R5 late piece");
        idle(1, "R5");
        tick(0, 0, 1, 50, 0, 0, 0, 0, 0, "R5 late chain silent");
        idle(6, "R5");
        // early second piece
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R5");
        idle(2, "R5");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R5 early piece");
        idle(2, "R5");
        tick(0, 0, 1, 50, 0, 0, 0, 0, 0, "R5 early chain silent");
        idle(6, "R5");
        // first piece again at the due cycle: restart at one
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R5");
        idle(3, "R5");
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R5 restart");
        idle(3, "R5");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R5");
        idle(1, "R5");
        tick(0, 0, 1, 50, 0, 0, 0, 1, 3, "R5 restarted chain");
        idle(6, "R5");
    endtask

    task automatic t_offgrid();
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R11");
        idle(1, "R11");
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R11 off-grid first piece");
        tick(1, 99, 0, 0, 0, 0, 0, 0, 0, "R11 off-grid other piece");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R11");
        idle(1, "R11");
        tick(0, 0, 1, 50, 0, 0, 0, 1, 3, "R11 chain survives");
        idle(6, "R11");
    endtask

    task automatic t_remnant();
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R6");
        idle(3, "R6");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R6");
        tick(0, 0, 1, 50, 0, 0, 0, 0, 0, "R6 early remnant");
        idle(1, "R6");
        tick(0, 0, 1, 50, 0, 0, 0, 0, 0, "R6 chain gone");
        idle(6, "R6");
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R6");
        idle(3, "R6");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R6");
        idle(1, "R6");
        tick(0, 0, 1, 51, 0, 0, 0, 0, 0, "R6 wrong remnant");
        idle(6, "R6");
    endtask

    task automatic t_tie();
        tick(1, 20, 0, 0, 0, 0, 0, 0, 0, "R7");
        idle(2, "R7");
        tick(0, 0, 1, 60, 0, 0, 0, 1, 5, "R7 lowest of 5 and 7");
        idle(6, "R7");
    endtask

    task automatic t_rewrite_len();
        cfg(5, 2, 0, 2);
        tick(1, 20, 0, 0, 0, 0, 0, 0, 0, "R2");
        idle(1, "R2");
        tick(0, 0, 1, 60, 0, 0, 0, 1, 5, "R2 new length of 5");
        idle(6, "R2");
        tick(1, 20, 0, 0, 0, 0, 0, 0, 0, "R2");
        idle(2, "R2");
        tick(0, 0, 1, 60, 0, 0, 0, 1, 7, "R2 old length only 7");
        idle(6, "R2");
        cfg(5, 2, 0, 3);
    endtask

    task automatic t_flush();
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R9");
        idle(1, "R9");
        tick(0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 flush");
        idle(1, "R9");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R9");
        idle(1, "R9");
        tick(0, 0, 1, 50, 0, 0, 0, 0, 0, "R9 flushed chain silent");
        idle(6, "R9");
        tick(1, 10, 0, 0, 0, 0, 1, 0, 0, "R9 piece with flush");
        idle(3, "R9");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R9");
        idle(1, "R9");
        tick(0, 0, 1, 50, 0, 0, 0, 0, 0, "R9 discarded start");
        idle(6, "R9");
        tick(1, 20, 0, 0, 0, 0, 0, 0, 0, "R9");
        idle(2, "R9");
        tick(0, 0, 1, 60, 0, 0, 1, 0, 0, "R9 remnant with flush");
        idle(6, "R9");
    endtask

    task automatic t_disabled();
        cfg(3, 3, 0, 0);
        tick(1, 10, 0, 0, 0, 0, 0, 0, 0, "R10");
        idle(3, "R10");
        tick(1, 11, 0, 0, 0, 0, 0, 0, 0, "R10");
        idle(1, "R10");
        tick(0, 0, 1, 50, 0, 0, 0, 0, 0, "R10 count zero silent");
        idle(6, "R10");
        cfg(3, 3, 0, 2);
    endtask

    task automatic t_short();
        tick(0, 0, 0, 0, 1, 77, 0, 0, 0, "R8 alone");
        tick(1, 20, 0, 0, 0, 0, 0, 0, 0, "R8");
        idle(2, "R8");
        tick(0, 0, 1, 60, 1, 42, 0, 1, 5, "R8 with long report");
        idle(6, "R8");
    endtask

    task automatic t_reset_mid();
        tick(1, 20, 0, 0, 0, 0, 0, 0, 0, "R1");
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        load_table();
        idle(1, "R1");
        tick(0, 0, 1, 60, 0, 0, 0, 0, 0, "R1 chain lost at reset");
        idle(6, "R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        load_table();
        idle(2, "R1");
        t_basic();
        t_three_pieces();
        t_mistimed();
        t_offgrid();
        t_remnant();
        t_tie();
        t_rewrite_len();
        t_flush();
        t_disabled();
        t_short();
        t_reset_mid();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule